// File: doc/BRIEF.md
# Instruction exception vector classifier

This block inspects each instruction at the moment it issues and decides whether that instruction must trap, and to which exception vector. It takes the first 16-bit opword, an issue strobe, a small set of decode flags, the current privilege mode, a debug bit that permits HALT in user mode, and a divisor-zero flag from the divider. From these it produces an exception request, the 8-bit vector number and the matching byte offset into the vector table.

The 4-bit line field at opword bits [15:12] picks the path. Lines 0xA and 0xF have their own vectors and do not share the generic illegal-opcode vector. Every other line uses the decoder's illegal flag. Privilege and divide checks follow in a fixed order. Only the first opword is examined, and extension words never affect the decision. The result is registered, so a request appears on the cycle after the issue strobe and lasts one cycle.

Top module: `exc_vec_classifier`

## Requirements
- R1: With issue valid, an opword whose bits [15:12] equal 0xA and whose `mac_ok` flag is low raises vector 10 (offset 0x028). With `mac_ok` high it raises nothing from the line check.
- R2: With issue valid, an opword whose bits [15:12] equal 0xF and whose `linef_ok` flag is low raises vector 11 (offset 0x02C). A supported line-F instruction (`linef_ok` high) raises nothing from the line check.
- R3: With issue valid, an opword on any line other than 0xA or 0xF with `illegal_op` high raises vector 4 (offset 0x010). On lines 0xA and 0xF, `illegal_op` has no effect.
- R4: With issue valid, `priv_op` high while `user_mode` is high raises vector 8 (offset 0x020). In supervisor mode (`user_mode` low), `priv_op` raises nothing.
- R5: A HALT (`halt_op` and `priv_op` both high) in user mode raises vector 8 when `uhalt_en` is low, and raises nothing when `uhalt_en` is high.
- R6: With issue valid, `div_zero` high raises vector 5 at offset 0x014.
- R7: When several causes hold together, the opword cause (vector 4, 10 or 11) wins over privilege (8), and privilege wins over divide-by-zero (5).
- R8: The offset output always equals the vector output multiplied by 4.
- R9: Outputs change on the clock edge after the issue cycle. A request lasts exactly one cycle per issue, and no request follows a cycle with `issue_vld` low.
- R10: During and after reset, and whenever no request is made, the request, vector and offset outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_vld | input | 1 | An instruction issues this cycle |
| opword | input | 16 | First opword of the issuing instruction |
| illegal_op | input | 1 | Decoder marks the opword as not a valid instruction |
| mac_ok | input | 1 | Line-0xA opword is a valid multiply-accumulate instruction |
| linef_ok | input | 1 | Line-0xF opword is one of the supported line-F instructions |
| priv_op | input | 1 | Instruction is supervisor-only |
| halt_op | input | 1 | Instruction is HALT |
| div_zero | input | 1 | Divide instruction with a zero divisor |
| user_mode | input | 1 | Processor is in user mode |
| uhalt_en | input | 1 | Debug setting that lets HALT run in user mode |
| exc_req | output | 1 | Exception request pulse |
| exc_vec | output | 8 | Exception vector number |
| exc_off | output | 10 | Vector-table byte offset |

## Verification
On every cycle, the embedded properties check that a request only follows an issue cycle, that no request follows an idle cycle, that a request never lasts two cycles without a second issue, that the vector is always one of the five legal values, that idle outputs are zero, and that the offset tracks the vector. The choice of which vector wins for a particular mix of line field, decode flags and mode is shown only by the bench scenarios. These include the ignored illegal flag on lines 0xA and 0xF, the user-halt exemption, and the stacked causes that exercise the priority order.

// File: rtl/exc_cls_pkg.sv
package exc_cls_pkg;
    localparam int OPW      = 16;
    localparam int LINEW    = 4;
    localparam int VECW     = 8;
    localparam int OFFW     = VECW + 2;

    localparam logic [LINEW-1:0] LINE_USER = 4'hA;
    localparam logic [LINEW-1:0] LINE_COPR = 4'hF;

    localparam logic [VECW-1:0] V_ILLEGAL = 8'd4;
    localparam logic [VECW-1:0] V_DIVZERO = 8'd5;
    localparam logic [VECW-1:0] V_PRIV    = 8'd8;
    localparam logic [VECW-1:0] V_LINE_A  = 8'd10;
    localparam logic [VECW-1:0] V_LINE_F  = 8'd11;

    typedef struct packed {
        logic ill;
        logic la;
        logic lf;
        logic priv;
        logic dz;
    } cause_t;

    typedef struct packed {
        logic            req;
        logic [VECW-1:0] vec;
        logic [OFFW-1:0] off;
    } exc_out_t;
endpackage

// File: rtl/exc_line_decode.sv
module exc_line_decode
    import exc_cls_pkg::*;
(
    input  logic [OPW-1:0] opword,
    input  logic           illegal_op,
    input  logic           mac_ok,
    input  logic           linef_ok,
    output logic           ill_c,
    output logic           la_c,
    output logic           lf_c
);
    logic [LINEW-1:0] line_fld;
    logic             is_a;
    logic             is_f;

    always_comb begin
        line_fld = opword[OPW-1 -: LINEW];
        is_a     = (line_fld == LINE_USER);
        is_f     = (line_fld == LINE_COPR);
        la_c     = is_a && !mac_ok;
        lf_c     = is_f && !linef_ok;
        ill_c    = !is_a && !is_f && illegal_op;
    end
endmodule

// File: rtl/exc_priv_check.sv
module exc_priv_check (
    input  logic priv_op,
    input  logic halt_op,
    input  logic user_mode,
    input  logic uhalt_en,
    output logic priv_c
);
    logic halt_exempt;

    always_comb begin
        halt_exempt = halt_op && uhalt_en;
        priv_c      = priv_op && user_mode && !halt_exempt;
    end
endmodule

// File: rtl/exc_priority_sel.sv
module exc_priority_sel
    import exc_cls_pkg::*;
(
    input  cause_t          causes,
    output logic            hit,
    output logic [VECW-1:0] vec,
    output logic [OFFW-1:0] off
);
    always_comb begin
        hit = 1'b1;
        vec = '0;
        if (causes.la)        vec = V_LINE_A;
        else if (causes.lf)   vec = V_LINE_F;
        else if (causes.ill)  vec = V_ILLEGAL;
        else if (causes.priv) vec = V_PRIV;
        else if (causes.dz)   vec = V_DIVZERO;
        else                  hit = 1'b0;
        off = {vec, 2'b00};
    end
endmodule

// File: rtl/exc_vec_classifier.sv
module exc_vec_classifier
    import exc_cls_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_vld,
    input  logic [OPW-1:0]  opword,
    input  logic            illegal_op,
    input  logic            mac_ok,
    input  logic            linef_ok,
    input  logic            priv_op,
    input  logic            halt_op,
    input  logic            div_zero,
    input  logic            user_mode,
    input  logic            uhalt_en,
    output logic            exc_req,
    output logic [VECW-1:0] exc_vec,
    output logic [OFFW-1:0] exc_off
);
    cause_t          cause_w;
    logic            hit_w;
    logic [VECW-1:0] vec_w;
    logic [OFFW-1:0] off_w;
    exc_out_t        st_d;
    exc_out_t        st_q;

    exc_line_decode u_line (
        .opword     (opword),
        .illegal_op (illegal_op),
        .mac_ok     (mac_ok),
        .linef_ok   (linef_ok),
        .ill_c      (cause_w.ill),
        .la_c       (cause_w.la),
        .lf_c       (cause_w.lf)
    );

    exc_priv_check u_priv (
        .priv_op   (priv_op),
        .halt_op   (halt_op),
        .user_mode (user_mode),
        .uhalt_en  (uhalt_en),
        .priv_c    (cause_w.priv)
    );

    assign cause_w.dz = div_zero;

    exc_priority_sel u_sel (
        .causes (cause_w),
        .hit    (hit_w),
        .vec    (vec_w),
        .off    (off_w)
    );

    always_comb begin
        st_d = '0;
        if (issue_vld && hit_w) begin
            st_d.req = 1'b1;
            st_d.vec = vec_w;
            st_d.off = off_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exc_req = st_q.req;
    assign exc_vec = st_q.vec;
    assign exc_off = st_q.off;

    // R9
    req_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(issue_vld));
    // R9
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> !exc_req);
    // R8
    off_tracks_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_off == OFFW'(exc_vec) * OFFW'(4));
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (exc_vec == '0 && exc_off == '0));
    // R7
    legal_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (exc_vec == V_ILLEGAL || exc_vec == V_DIVZERO ||
                     exc_vec == V_PRIV || exc_vec == V_LINE_A ||
                     exc_vec == V_LINE_F));
    // R1
    line_a_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && opword[OPW-1 -: LINEW] == LINE_USER && !mac_ok)
        |=> (exc_req && exc_vec == V_LINE_A));
endmodule

// File: tb/tb_exc_vec_classifier.sv
module tb_exc_vec_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [15:0] opword = '0;
    logic        illegal_op = 1'b0, mac_ok = 1'b0, linef_ok = 1'b0;
    logic        priv_op = 1'b0, halt_op = 1'b0, div_zero = 1'b0;
    logic        user_mode = 1'b0, uhalt_en = 1'b0;
    logic        exc_req;
    logic [7:0]  exc_vec;
    logic [9:0]  exc_off;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        bit       req;
        bit [7:0] vec;
        bit [9:0] off;
        string    tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    exc_vec_classifier dut (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .opword(opword),
        .illegal_op(illegal_op), .mac_ok(mac_ok), .linef_ok(linef_ok),
        .priv_op(priv_op), .halt_op(halt_op), .div_zero(div_zero),
        .user_mode(user_mode), .uhalt_en(uhalt_en),
        .exc_req(exc_req), .exc_vec(exc_vec), .exc_off(exc_off)
    );

    function automatic bit [7:0] model_vec(input bit v, input bit [15:0] op,
        input bit ill, input bit mac, input bit lf, input bit pr,
        input bit hl, input bit dz, input bit um, input bit uhe);
        bit [3:0] ln;
        ln = op[15:12];
        if (!v)                              return 8'd0;
        if (ln == 4'hA)      begin if (!mac) return 8'd10; end
        else if (ln == 4'hF) begin if (!lf)  return 8'd11; end
        else if (ill)                        return 8'd4;
        if (pr && um && !(hl && uhe))        return 8'd8;
        if (dz)                              return 8'd5;
        return 8'd0;
    endfunction

    task automatic drive(input bit v, input bit [15:0] op, input bit ill,
        input bit mac, input bit lf, input bit pr, input bit hl,
        input bit dz, input bit um, input bit uhe, input string tag);
        exp_t e;
        @(negedge clk);
        issue_vld = v; opword = op; illegal_op = ill; mac_ok = mac;
        linef_ok = lf; priv_op = pr; halt_op = hl; div_zero = dz;
        user_mode = um; uhalt_en = uhe;
        e.vec = model_vec(v, op, ill, mac, lf, pr, hl, dz, um, uhe);
        e.req = (e.vec != 0);
        e.off = {2'b00, e.vec} * 10'd4;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(0, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb.size() > 0) begin
                e = sb.pop_front();
                total++;
                if (exc_req !== e.req || exc_vec !== e.vec || exc_off !== e.off) begin
                    bad++;
                    $display("FAIL %s: req/vec/off actual %0b/%0d/0x%0h expected %0b/%0d/0x%0h",
                             e.tag, exc_req, exc_vec, exc_off, e.req, e.vec, e.off);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 20000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        total++;
        if (exc_req !== 1'b0 || exc_vec !== 8'd0 || exc_off !== 10'd0) begin
            bad++;
            $display("FAIL R10 reset: actual %0b/%0d/%0d expected 0/0/0", exc_req, exc_vec, exc_off);
        end
        rst_n = 1'b1;
        idle("R10 idle after reset");
        //             v  op        ill mac lf pr hl dz um uhe
        drive(1, 16'hA1C0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 line A non-MAC");
        drive(1, 16'hA1C0, 0, 1, 0, 0, 0, 0, 0, 0, "R1 line A valid MAC");
        drive(1, 16'hF4E8, 0, 0, 0, 0, 0, 0, 0, 0, "R2 line F unsupported");
        drive(1, 16'hF4E8, 0, 0, 1, 0, 0, 0, 0, 0, "R2 line F supported");
        drive(1, 16'h4AFC, 1, 0, 0, 0, 0, 0, 0, 0, "R3 illegal line 4");
        drive(1, 16'h0000, 1, 0, 0, 0, 0, 0, 1, 0, "R3 illegal line 0");
        drive(1, 16'hA000, 1, 1, 0, 0, 0, 0, 0, 0, "R3 illegal ignored line A");
        drive(1, 16'hF000, 1, 0, 1, 0, 0, 0, 0, 0, "R3 illegal ignored line F");
        drive(1, 16'h46FC, 0, 0, 0, 1, 0, 0, 1, 0, "R4 priv in user");
        drive(1, 16'h46FC, 0, 0, 0, 1, 0, 0, 0, 0, "R4 priv in supervisor");
        drive(1, 16'h4AC8, 0, 0, 0, 1, 1, 0, 1, 0, "R5 halt user no enable");
        drive(1, 16'h4AC8, 0, 0, 0, 1, 1, 0, 1, 1, "R5 halt user enabled");
        drive(1, 16'h4AC8, 0, 0, 0, 1, 0, 0, 1, 1, "R5 enable only exempts halt");
        drive(1, 16'h4C40, 0, 0, 0, 0, 0, 1, 0, 0, "R6 divide by zero");
        drive(1, 16'h4AFC, 1, 0, 0, 1, 0, 1, 1, 0, "R7 illegal over priv and div");
        drive(1, 16'hA000, 0, 0, 0, 1, 0, 1, 1, 0, "R7 line A over priv");
        drive(1, 16'h4C40, 0, 0, 0, 1, 0, 1, 1, 0, "R7 priv over div");
        drive(1, 16'hF000, 0, 0, 0, 0, 0, 1, 0, 0, "R7 line F over div");
        drive(0, 16'hA000, 1, 0, 0, 1, 0, 1, 1, 0, "R9 no issue no request");
        drive(1, 16'h4C40, 0, 0, 0, 0, 0, 1, 0, 0, "R8 offset for div");
        idle("R9 single pulse");
        drive(1, 16'hF000, 0, 0, 0, 0, 0, 0, 0, 0, "R8 offset for line F");
        drive(1, 16'hF000, 0, 0, 0, 0, 0, 0, 0, 0, "R9 back to back");
        idle("R9 pulse ends");
        idle("R10 quiet");
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule